// File: doc/BRIEF.md
# PRBS Pattern Detector with Sync Monitor

This block checks a serial bit stream against a pseudo-random test pattern chosen from three feedback polynomials. It needs no seed from outside. After the test enable rises, it loads the received bits into its own shift register, then predicts each following bit from that register. Once enough consecutive predictions come true, the block declares synchronization. From then on the register runs free, and every received bit that disagrees with the prediction counts as one bit error.

The error density is judged over consecutive, non-overlapping windows of 48 accepted bits. When the count in one window goes past ten, the detector drops synchronization and starts acquiring again from the incoming data. There are two sticky event flags: one for bit errors and one for any change of the sync state. Each flag has its own interrupt enable, and the enabled flags are combined onto one interrupt pin. Each bit error also appears as a one-cycle pulse that a performance counter can count.

Bits enter on a valid/ready stream interface. The detector never applies back-pressure: `in_ready` is always high, so `in_valid` acts as a bit strobe and every cycle with `in_valid` high delivers exactly one bit. Cycles with `in_valid` low are idle and change nothing in the checker.

Top module: `prbs_mon_top`

## Requirements
- R1: While `test_en` is low, received bits are ignored, `sync_o` is 0 and no error pulse occurs. A 0-to-1 transition of `test_en` starts acquisition, and the bit strobed in that same cycle is not used.
- R2: When `rx_inv` is 1, every received bit is inverted before checking. A stream whose polarity does not match `rx_inv` never reaches sync and produces no error pulse.
- R3: `pat_sel` selects the recurrence: 00 gives b[t]=b[t-11]^b[t-9], 01 gives b[t]=b[t-15]^b[t-14], 10 gives b[t]=b[t-20]^b[t-17], and 11 behaves as 00.
- R4: For a pattern of order L, the first L accepted bits fill the register. `sync_o` becomes 1 after the clock edge that accepts the 32nd consecutive correctly predicted bit, which is accepted bit index L+31 counting from 0. It is still 0 after index L+30.
- R5: While in sync, each accepted bit that differs from the prediction gives a one-cycle `err_pulse` in the cycle after it is accepted. A single flipped bit causes exactly one error.
- R6: While in sync, accepted bits are grouped into windows of 48, starting with the first bit after sync is declared. When an 11th error falls inside one window, `sync_o` drops after that bit. Ten errors at the end of one window followed by ten errors at the start of the next do not drop sync.
- R7: After a loss of sync, the detector reloads its register from the incoming bits and regains sync on a clean stream.
- R8: `ber_flag` is set by every error pulse, and `sync_chg_flag` is set by every rise or fall of `sync_o`. Each flag stays set until its clear strobe (`ber_clr` or `sync_clr`). An event in the same cycle as the clear keeps the flag set.
- R9: `irq` is 1 exactly when (`ber_flag` and `ber_irq_en`) or (`sync_chg_flag` and `sync_irq_en`).
- R10: `in_ready` is 1 at all times. Only cycles with `in_valid` high deliver a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Bit strobe of the input stream |
| in_data | input | 1 | Received bit |
| in_ready | output | 1 | Always 1; the detector never stalls the stream |
| pat_sel | input | 2 | Pattern select (encoding in R3) |
| test_en | input | 1 | Detector enable; a rising edge starts acquisition |
| rx_inv | input | 1 | Invert received bits before checking |
| ber_irq_en | input | 1 | Interrupt enable for the bit-error flag |
| sync_irq_en | input | 1 | Interrupt enable for the sync-change flag |
| ber_clr | input | 1 | Clear strobe for the bit-error flag |
| sync_clr | input | 1 | Clear strobe for the sync-change flag |
| sync_o | output | 1 | Synchronization status |
| ber_flag | output | 1 | Sticky bit-error flag |
| sync_chg_flag | output | 1 | Sticky sync-change flag |
| err_pulse | output | 1 | One-cycle pulse per detected bit error |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest case to reach from the ports is the window boundary. Error density only matters relative to windows that start at the hidden moment sync is declared. The bench therefore counts accepted bits from the rise of `test_en`, so it knows the exact sync bit (index L+31), and places flipped bits at chosen offsets from there. This lets it send eleven errors inside one window, and also twenty errors split ten and ten across a boundary. Clearing a flag in the same cycle as a new event is reached by waiting for the visible error pulse and raising the clear strobe in that very cycle.

// File: rtl/prbs_mon_pkg.sv
package prbs_mon_pkg;

  localparam int unsigned SR_MAX = 20;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_HUNT,
    ST_LOCK
  } mon_state_e;

  // order of the selected recurrence (register bits needed)
  function automatic int unsigned poly_order(input logic [1:0] sel);
    case (sel)
      2'b01:   return 15;
      2'b10:   return 20;
      default: return 11;
    endcase
  endfunction

  // first feedback tap distance
  function automatic int unsigned poly_tap_a(input logic [1:0] sel);
    return poly_order(sel);
  endfunction

  // second feedback tap distance
  function automatic int unsigned poly_tap_b(input logic [1:0] sel);
    case (sel)
      2'b01:   return 14;
      2'b10:   return 17;
      default: return 9;
    endcase
  endfunction

endpackage

// File: rtl/prbs_mon_lfsr.sv
module prbs_mon_lfsr
  import prbs_mon_pkg::*;
#(
  parameter int unsigned SR_W = SR_MAX
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shift,
  input  logic       load_rx,
  input  logic       rx_bit,
  input  logic [1:0] sel,
  output logic       pred
);

  logic [SR_W-1:0] sr_q;
  logic [SR_W-1:0] sr_d;
  logic            new_bit;
  logic            tap_a_bit;
  logic            tap_b_bit;

  // sr_q[0] holds the most recent bit, sr_q[k-1] the bit k steps back
  always_comb begin
    tap_a_bit = 1'b0;
    tap_b_bit = 1'b0;
    for (int unsigned k = 1; k <= SR_W; k++) begin
      if (k == poly_tap_a(sel)) tap_a_bit = sr_q[k-1];
      if (k == poly_tap_b(sel)) tap_b_bit = sr_q[k-1];
    end
  end

  assign pred    = tap_a_bit ^ tap_b_bit;
  assign new_bit = load_rx ? rx_bit : pred;

  assign sr_d[0] = new_bit;
  generate
    for (genvar g = 1; g < SR_W; g++) begin : g_chain
      assign sr_d[g] = sr_q[g-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) sr_q <= '0;
    else if (shift) sr_q <= sr_d;
  end

endmodule

// File: rtl/prbs_mon_sync.sv
module prbs_mon_sync
  import prbs_mon_pkg::*;
#(
  parameter int unsigned SR_W       = SR_MAX,
  parameter int unsigned MATCH_NEED = 32,
  parameter int unsigned WIN_LEN    = 48,
  parameter int unsigned ERR_LIMIT  = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       test_en,
  input  logic       bit_vld,
  input  logic       rx_bit,
  input  logic       pred,
  input  logic [1:0] sel,
  output logic       shift,
  output logic       load_rx,
  output logic       sync_o,
  output logic       err_pulse_o
);

  localparam int unsigned FW = $clog2(SR_W + 1);
  localparam int unsigned MW = $clog2(MATCH_NEED);
  localparam int unsigned WW = $clog2(WIN_LEN);
  localparam int unsigned EW = $clog2(ERR_LIMIT + 1);

  mon_state_e    state_q;
  logic          te_q;
  logic [FW-1:0] fill_q;
  logic [MW-1:0] match_q;
  logic [WW-1:0] win_q;
  logic [EW-1:0] errc_q;
  logic [FW-1:0] fill_last;
  logic          mis;
  logic          take;

  assign fill_last = FW'(poly_order(sel) - 1);
  assign mis       = rx_bit ^ pred;
  assign take      = bit_vld & test_en & te_q;
  assign shift     = take & (state_q != ST_IDLE);
  assign load_rx   = (state_q != ST_LOCK);
  assign sync_o    = (state_q == ST_LOCK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      te_q        <= 1'b0;
      fill_q      <= '0;
      match_q     <= '0;
      win_q       <= '0;
      errc_q      <= '0;
      err_pulse_o <= 1'b0;
    end else begin
      te_q        <= test_en;
      err_pulse_o <= 1'b0;
      if (!test_en) begin
        state_q <= ST_IDLE;
        fill_q  <= '0;
        match_q <= '0;
        win_q   <= '0;
        errc_q  <= '0;
      end else if (!te_q) begin
        state_q <= ST_FILL;
        fill_q  <= '0;
        match_q <= '0;
      end else if (bit_vld) begin
        case (state_q)
          ST_FILL: begin
            if (fill_q == fill_last) begin
              state_q <= ST_HUNT;
              match_q <= '0;
            end else begin
              fill_q <= fill_q + 1'b1;
            end
          end
          ST_HUNT: begin
            if (mis) begin
              match_q <= '0;
            end else if (match_q == MW'(MATCH_NEED - 1)) begin
              state_q <= ST_LOCK;
              win_q   <= '0;
              errc_q  <= '0;
            end else begin
              match_q <= match_q + 1'b1;
            end
          end
          ST_LOCK: begin
            err_pulse_o <= mis;
            if (mis && (errc_q == EW'(ERR_LIMIT))) begin
              state_q <= ST_FILL;
              fill_q  <= '0;
            end else if (win_q == WW'(WIN_LEN - 1)) begin
              win_q  <= '0;
              errc_q <= '0;
            end else begin
              win_q  <= win_q + 1'b1;
              errc_q <= errc_q + EW'(mis);
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_idle_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |=> !sync_o);

  p_lock_from_hunt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_o) |-> ($past(state_q) == ST_HUNT) && $past(bit_vld));

  p_err_needs_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse_o |-> $past(sync_o));

  p_err_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |-> (errc_q <= EW'(ERR_LIMIT)) && (win_q < WW'(WIN_LEN)));

  p_loss_by_errors_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sync_o) && $past(test_en)) |-> ($past(mis) && ($past(errc_q) == EW'(ERR_LIMIT))));

endmodule

// File: rtl/prbs_mon_flags.sv
module prbs_mon_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ber_evt,
  input  logic sync_now,
  input  logic ber_clr,
  input  logic sync_clr,
  input  logic ber_en,
  input  logic sync_en,
  output logic ber_flag,
  output logic chg_flag,
  output logic irq
);

  logic sync_q;
  logic chg_evt;

  assign chg_evt = sync_now ^ sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q   <= 1'b0;
      ber_flag <= 1'b0;
      chg_flag <= 1'b0;
    end else begin
      sync_q   <= sync_now;
      ber_flag <= ber_evt | (ber_flag & ~ber_clr);
      chg_flag <= chg_evt | (chg_flag & ~sync_clr);
    end
  end

  assign irq = (ber_flag & ber_en) | (chg_flag & sync_en);

  p_ber_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ber_flag && !ber_clr) |=> ber_flag);

  p_ber_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ber_evt |=> ber_flag);

  p_chg_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_now != sync_q) |=> chg_flag);

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ber_en && !sync_en) |-> !irq);

endmodule

// File: rtl/prbs_mon_top.sv
module prbs_mon_top
  import prbs_mon_pkg::*;
#(
  parameter int unsigned SR_W       = SR_MAX,
  parameter int unsigned MATCH_NEED = 32,
  parameter int unsigned WIN_LEN    = 48,
  parameter int unsigned ERR_LIMIT  = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_data,
  output logic       in_ready,
  input  logic [1:0] pat_sel,
  input  logic       test_en,
  input  logic       rx_inv,
  input  logic       ber_irq_en,
  input  logic       sync_irq_en,
  input  logic       ber_clr,
  input  logic       sync_clr,
  output logic       sync_o,
  output logic       ber_flag,
  output logic       sync_chg_flag,
  output logic       err_pulse,
  output logic       irq
);

  logic rx_bit;
  logic pred;
  logic shift;
  logic load_rx;

  assign in_ready = 1'b1;
  assign rx_bit   = in_data ^ rx_inv;

  prbs_mon_lfsr #(.SR_W(SR_W)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift   (shift),
    .load_rx (load_rx),
    .rx_bit  (rx_bit),
    .sel     (pat_sel),
    .pred    (pred)
  );

  prbs_mon_sync #(
    .SR_W       (SR_W),
    .MATCH_NEED (MATCH_NEED),
    .WIN_LEN    (WIN_LEN),
    .ERR_LIMIT  (ERR_LIMIT)
  ) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .test_en     (test_en),
    .bit_vld     (in_valid),
    .rx_bit      (rx_bit),
    .pred        (pred),
    .sel         (pat_sel),
    .shift       (shift),
    .load_rx     (load_rx),
    .sync_o      (sync_o),
    .err_pulse_o (err_pulse)
  );

  prbs_mon_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .ber_evt  (err_pulse),
    .sync_now (sync_o),
    .ber_clr  (ber_clr),
    .sync_clr (sync_clr),
    .ber_en   (ber_irq_en),
    .sync_en  (sync_irq_en),
    .ber_flag (ber_flag),
    .chg_flag (sync_chg_flag),
    .irq      (irq)
  );

endmodule

// File: tb/test_prbs_mon_top.sv
`timescale 1ns/1ps
module test_prbs_mon_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, in_valid, in_data, in_ready;
  logic [1:0] pat_sel;
  logic       test_en, rx_inv, ber_irq_en, sync_irq_en, ber_clr, sync_clr;
  logic       sync_o, ber_flag, sync_chg_flag, err_pulse, irq;

  prbs_mon_top i_prbs_mon_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .pat_sel(pat_sel), .test_en(test_en), .rx_inv(rx_inv),
    .ber_irq_en(ber_irq_en), .sync_irq_en(sync_irq_en), .ber_clr(ber_clr),
    .sync_clr(sync_clr), .sync_o(sync_o), .ber_flag(ber_flag),
    .sync_chg_flag(sync_chg_flag), .err_pulse(err_pulse), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  int err_seen = 0;
  logic [19:0] hist;
  int ta, tb;

  // fields: sel[19:18] rinv[17] txinv[16] err_start[15:8] err_cnt[7:0]
  localparam int NV = 7;
  localparam logic [19:0] VECS [0:NV-1] = '{
    {2'b00, 1'b0, 1'b0, 8'd5,  8'd3},
    {2'b01, 1'b1, 1'b1, 8'd0,  8'd0},
    {2'b10, 1'b0, 1'b0, 8'd0,  8'd11},
    {2'b00, 1'b0, 1'b1, 8'd0,  8'd0},
    {2'b11, 1'b0, 1'b0, 8'd38, 8'd20},
    {2'b01, 1'b0, 1'b0, 8'd10, 8'd10},
    {2'b10, 1'b1, 1'b0, 8'd0,  8'd0}
  };

  always @(negedge clk) if (err_pulse === 1'b1) err_seen++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_poly(input logic [1:0] s);
    case (s)
      2'b01:   begin ta = 15; tb = 14; end
      2'b10:   begin ta = 20; tb = 17; end
      default: begin ta = 11; tb = 9;  end
    endcase
    hist = '1;
  endtask

  task automatic send(input logic b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_pat(input logic inv, input logic flip);
    logic b;
    b = hist[ta-1] ^ hist[tb-1];
    hist = {hist[18:0], b};
    send(b ^ inv ^ flip);
  endtask

  task automatic pulse_clears();
    ber_clr = 1'b1; sync_clr = 1'b1;
    @(negedge clk);
    ber_clr = 1'b0; sync_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic start_test();
    test_en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual 0 expected 1 (run finished)");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = 1'b0; pat_sel = 2'b00;
    test_en = 1'b0; rx_inv = 1'b0; ber_irq_en = 1'b0; sync_irq_en = 1'b0;
    ber_clr = 1'b0; sync_clr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check("R10 in_ready after reset", int'(in_ready), 1);
    check("R1 sync after reset", int'(sync_o), 0);
    check("R8 ber_flag after reset", int'(ber_flag), 0);
    check("R8 sync_chg_flag after reset", int'(sync_chg_flag), 0);
    check("R9 irq after reset", int'(irq), 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [1:0] sel;
      logic       rinv, txinv;
      int         st, cnt, len, e_exp, wcnt;
      logic       lost;
      sel   = VECS[v][19:18];
      rinv  = VECS[v][17];
      txinv = VECS[v][16];
      st    = int'(VECS[v][15:8]);
      cnt   = int'(VECS[v][7:0]);
      test_en = 1'b0; pat_sel = sel; rx_inv = rinv;
      repeat (3) @(negedge clk);
      pulse_clears();
      set_poly(sel);
      len = ta;
      err_seen = 0;
      start_test();
      if (rinv == txinv) begin
        for (int i = 0; i < len + 31; i++) send_pat(txinv, 1'b0);
        check("R4 sync before last matching bit (R3 pattern)", int'(sync_o), 0);
        send_pat(txinv, 1'b0);
        check("R4 sync at last matching bit (R3 pattern)", int'(sync_o), 1);
        e_exp = 0; wcnt = 0; lost = 1'b0;
        for (int off = 0; off < 110; off++) begin
          logic flip;
          if (off % 48 == 0) wcnt = 0;
          flip = (off >= st) && (off < st + cnt) && !lost;
          send_pat(txinv, flip);
          if (flip) begin
            e_exp++;
            wcnt++;
            if (wcnt > 10) begin
              lost = 1'b1;
              check("R6 sync dropped on 11th error in window", int'(sync_o), 0);
            end
          end
        end
        if (!lost) check("R6 sync held below window limit", int'(sync_o), 1);
        check("R5 error pulse count", err_seen, e_exp);
        for (int i = 0; i < 80; i++) send_pat(txinv, 1'b0);
        check("R7 sync on clean stream after run", int'(sync_o), 1);
        check("R8 ber_flag after errors", int'(ber_flag), (e_exp > 0) ? 1 : 0);
      end else begin
        for (int i = 0; i < 200; i++) send_pat(txinv, 1'b0);
        check("R2 no sync on wrong polarity", int'(sync_o), 0);
        check("R2 no error pulse on wrong polarity", err_seen, 0);
      end
    end

    // R1: disabled detector ignores data
    test_en = 1'b0; pat_sel = 2'b00; rx_inv = 1'b0;
    repeat (3) @(negedge clk);
    pulse_clears();
    set_poly(2'b00);
    err_seen = 0;
    for (int i = 0; i < 80; i++) send_pat(1'b0, (i % 9) == 0);
    check("R1 no sync while disabled", int'(sync_o), 0);
    check("R1 no error pulse while disabled", err_seen, 0);
    check("R1 no sync change while disabled", int'(sync_chg_flag), 0);

    // flags and interrupts
    set_poly(2'b00);
    start_test();
    for (int i = 0; i < 11 + 32; i++) send_pat(1'b0, 1'b0);
    @(negedge clk);
    check("R4 sync in directed run", int'(sync_o), 1);
    check("R8 sync change flag on rise", int'(sync_chg_flag), 1);
    sync_irq_en = 1'b1; ber_irq_en = 1'b0;
    @(negedge clk);
    check("R9 irq from sync change flag", int'(irq), 1);
    sync_irq_en = 1'b0;
    @(negedge clk);
    check("R9 irq masked", int'(irq), 0);
    sync_clr = 1'b1;
    @(negedge clk);
    sync_clr = 1'b0;
    check("R8 sync change flag cleared", int'(sync_chg_flag), 0);
    send_pat(1'b0, 1'b1);
    for (int i = 0; i < 5; i++) send_pat(1'b0, 1'b0);
    check("R8 ber_flag sticky", int'(ber_flag), 1);
    ber_irq_en = 1'b1;
    @(negedge clk);
    check("R9 irq from ber_flag", int'(irq), 1);
    ber_clr = 1'b1;
    @(negedge clk);
    ber_clr = 1'b0;
    check("R8 ber_flag cleared", int'(ber_flag), 0);
    check("R9 irq after clear", int'(irq), 0);
    send_pat(1'b0, 1'b1);
    check("R5 error pulse visible", int'(err_pulse), 1);
    ber_clr = 1'b1;
    @(negedge clk);
    ber_clr = 1'b0;
    check("R8 event wins over clear", int'(ber_flag), 1);
    pulse_clears();
    sync_irq_en = 1'b1; ber_irq_en = 1'b0;
    test_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 sync off after disable", int'(sync_o), 0);
    check("R8 sync change flag on fall", int'(sync_chg_flag), 1);
    check("R9 irq on fall", int'(irq), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule